// File: doc/BRIEF.md
# Multiplexed LCD Row/Column Drive Sequencer

This block scans an eight-row display memory and drives a symbolic bias-level code for each of 60 LCD driver outputs. The multiplex ratio can be set to 2, 4 or 8. The row counter steps once per row period. At the end of every frame the drive phase flips between positive and negative, so the average voltage across each pixel stays free of DC. Each output is either a row driver or a column driver. In row-and-column mode the first n outputs act as rows and the rest act as columns. In column-only mode all 60 outputs act as columns, which suits a driver cascaded behind a master.

The row timebase depends on the mode. In row-and-column mode it comes from an internal divider of the system clock, and each internal row step toggles `frame_out`. In column-only mode the block follows a master: `frame_in` is synchronized, and each of its edges advances the row. Blank and force-on controls override the column data. A sync pulse restarts the scan at the first row in the positive phase.

The phase register is an enumerated state machine:
- `PH_POS` moves to `PH_NEG` on a row tick at the last row of the frame.
- `PH_NEG` moves to `PH_POS` on a row tick at the last row.
- A sync pulse sends either state to `PH_POS`.
- Every other case holds the state.

Top module: `lcd_mux_sequencer`

## Requirements
- R1: After reset, all memory rows read as zero, the scan is at row index 0 in the positive phase, and `frame_out` is 0.
- R2: The multiplex select `mux_sel` uses codes 00 = 2 rows, 01 = 4 rows, 10 and 11 = 8 rows. When `col_only` is 0, outputs 0..n-1 are rows and outputs n..59 are columns. When `col_only` is 1, all 60 outputs are columns.
- R3: Output k drives a 3-bit code at bits [3k+2:3k]. The codes are VSS=0, V3=1, V2=2, V1=3, VLCD=4. A column is on when bit k of the current row's memory word is 1. An on column drives VLCD in the positive phase and VSS in the negative phase. An off column drives V2 in the positive phase and V1 in the negative phase.
- R4: The selected row output (index equal to the row counter) drives VSS in the positive phase and VLCD in the negative phase. Unselected rows drive V1 in the positive phase. In the negative phase they drive V3, or V2 in 4-row mode. In 4-row mode no output ever drives V3.
- R5: In row-and-column mode the row advances every ROW_DIV clocks. After row n-1 it wraps to row 0, and the phase flips at that wrap.
- R6: In row-and-column mode `frame_out` toggles on every internal row step. In column-only mode it holds its value.
- R7: In column-only mode each edge of `frame_in` advances the row on the third clock edge after the change. The internal divider does not move the row in this mode.
- R8: `blank` forces every column off and `force_on` forces every column on. If both are asserted, `blank` wins. Row outputs are unaffected.
- R9: A `sync` pulse sets row 0, the positive phase and a fresh divider period at the next clock edge.
- R10: A write with `wr_en` stores `wr_data` in row `wr_row` at the clock edge. The new word is visible at the outputs from then on.
- R11: If the row counter is at or above n after `mux_sel` changes, it returns to row 0 at the next clock edge without a phase change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mux_sel | input | 2 | Multiplex ratio select |
| col_only | input | 1 | 1 = all outputs are columns, row timing from `frame_in` |
| blank | input | 1 | Force all columns off |
| force_on | input | 1 | Force all columns on |
| sync | input | 1 | Restart scan at row 0, positive phase |
| frame_in | input | 1 | External row timing (asynchronous) |
| frame_out | output | 1 | Row timing for cascaded drivers |
| wr_en | input | 1 | Display memory write strobe |
| wr_row | input | 3 | Row address of the write |
| wr_data | input | 60 | Row word to write |
| drive | output | 180 | 3-bit level code per output |

## Verification
The assertions assume three things about the inputs. First, `mux_sel` holds for at least one cycle before the row bound is checked. Second, `sync` is a single-cycle pulse. Third, `frame_in` changes far less often than once per three clocks, so each of its edges is seen once. The bench follows these rules. It changes configuration only between row periods. It drives every input one nanosecond after a clock edge. It leaves at least three clocks between `frame_in` toggles and holds each level for that whole span. Expected drive codes come from a per-output arithmetic model of row/column role, phase and memory word. This model is swept over every mux code and every row of two full frames.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int MAX_ROWS = 8;
    localparam int LVL_W    = 3;

    typedef enum logic [2:0] {
        LVL_VSS  = 3'd0,
        LVL_V3   = 3'd1,
        LVL_V2   = 3'd2,
        LVL_V1   = 3'd3,
        LVL_VLCD = 3'd4
    } lvl_e;

    typedef enum logic [0:0] {
        PH_POS = 1'b0,
        PH_NEG = 1'b1
    } phase_e;

    function automatic logic [3:0] rows_of(input logic [1:0] sel);
        logic [3:0] n;
        unique case (sel)
            2'b00:   n = 4'd2;
            2'b01:   n = 4'd4;
            default: n = 4'd8;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/lcd_row_timebase.sv
module lcd_row_timebase
    import lcd_seq_pkg::*;
#(
    parameter int ROW_DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic col_only,
    input  logic sync,
    input  logic frame_in,
    output logic row_tick,
    output logic frame_out
);
    localparam int CNT_W = (ROW_DIV > 2) ? $clog2(ROW_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROW_DIV - 1);

    logic [CNT_W-1:0] div_q;
    logic             int_tick;
    logic             fs1_q, fs2_q, fs3_q;
    logic             ext_tick;
    logic             fo_q;

    assign int_tick = (div_q == CNT_LAST);
    assign ext_tick = fs2_q ^ fs3_q;
    assign row_tick = col_only ? ext_tick : int_tick;
    assign frame_out = fo_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (sync || int_tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs1_q <= 1'b0;
            fs2_q <= 1'b0;
            fs3_q <= 1'b0;
        end else begin
            fs1_q <= frame_in;
            fs2_q <= fs1_q;
            fs3_q <= fs2_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fo_q <= 1'b0;
        end else if (!col_only && int_tick && !sync) begin
            fo_q <= ~fo_q;
        end
    end

    a_r6_frame_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_only && row_tick && !sync) |=> (frame_out != $past(frame_out)));

    a_r6_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(col_only) |-> $stable(frame_out));

endmodule

// File: rtl/lcd_scan_fsm.sv
module lcd_scan_fsm
    import lcd_seq_pkg::*;
#(
    parameter int ROWS = MAX_ROWS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     row_tick,
    input  logic                     sync,
    input  logic [3:0]               n_rows,
    output logic [$clog2(ROWS)-1:0]  row_idx,
    output phase_e                   phase
);
    localparam int RW = $clog2(ROWS);

    phase_e        ph_q, ph_d;
    logic [RW-1:0] row_q, row_d;
    logic          at_last;
    logic          out_of_range;

    assign at_last      = ({1'b0, row_q} == (n_rows - 4'd1));
    assign out_of_range = ({1'b0, row_q} >= n_rows);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= PH_POS;
            row_q <= '0;
        end else begin
            ph_q  <= ph_d;
            row_q <= row_d;
        end
    end

    always_comb begin
        ph_d  = ph_q;
        row_d = row_q;
        if (sync) begin
            ph_d  = PH_POS;
            row_d = '0;
        end else if (out_of_range) begin
            row_d = '0;
        end else if (row_tick) begin
            unique case (ph_q)
                PH_POS: if (at_last) ph_d = PH_NEG;
                PH_NEG: if (at_last) ph_d = PH_POS;
            endcase
            row_d = at_last ? '0 : row_q + 1'b1;
        end
    end

    assign row_idx = row_q;
    assign phase   = ph_q;

    a_r9_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        sync |=> (row_idx == '0 && phase == PH_POS));

    a_r5_flip_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tick && !sync && !out_of_range && at_last) |=> (phase != $past(phase) && row_idx == '0));

    a_r5_row_step: assert property (@(posedge clk) disable iff (!rst_n)
        (row_tick && !sync && !out_of_range && !at_last) |=> (row_idx == $past(row_idx) + 1'b1 && phase == $past(phase)));

    a_r11_row_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(n_rows) |-> ({1'b0, row_idx} < n_rows));

endmodule

// File: rtl/lcd_level_map.sv
module lcd_level_map
    import lcd_seq_pkg::*;
#(
    parameter int OUTS = 60,
    parameter int ROWS = MAX_ROWS
) (
    input  logic [$clog2(ROWS)-1:0] row_idx,
    input  phase_e                  phase,
    input  logic [3:0]              n_rows,
    input  logic                    col_only,
    input  logic                    blank,
    input  logic                    force_on,
    input  logic [OUTS-1:0]         row_word,
    output logic [OUTS*LVL_W-1:0]   drive
);
    logic mux4;
    assign mux4 = (n_rows == 4'd4);

    for (genvar k = 0; k < OUTS; k++) begin : g_out
        logic is_row;
        logic sel;
        logic pix_on;
        lvl_e code;

        assign is_row = !col_only && (int'(n_rows) > k);
        assign sel    = (int'(row_idx) == k);
        assign pix_on = blank ? 1'b0 : (force_on ? 1'b1 : row_word[k]);

        always_comb begin
            code = LVL_V2;
            if (is_row) begin
                unique case (phase)
                    PH_POS: code = sel ? LVL_VSS  : LVL_V1;
                    PH_NEG: code = sel ? LVL_VLCD : (mux4 ? LVL_V2 : LVL_V3);
                endcase
            end else begin
                unique case (phase)
                    PH_POS: code = pix_on ? LVL_VLCD : LVL_V2;
                    PH_NEG: code = pix_on ? LVL_VSS  : LVL_V1;
                endcase
            end
        end

        assign drive[k*LVL_W +: LVL_W] = code;
    end

endmodule

// File: rtl/lcd_mux_sequencer.sv
module lcd_mux_sequencer
    import lcd_seq_pkg::*;
#(
    parameter int OUTS    = 60,
    parameter int ROWS    = MAX_ROWS,
    parameter int ROW_DIV = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mux_sel,
    input  logic                      col_only,
    input  logic                      blank,
    input  logic                      force_on,
    input  logic                      sync,
    input  logic                      frame_in,
    output logic                      frame_out,
    input  logic                      wr_en,
    input  logic [$clog2(ROWS)-1:0]   wr_row,
    input  logic [OUTS-1:0]           wr_data,
    output logic [OUTS*LVL_W-1:0]     drive
);
    localparam int RW = $clog2(ROWS);

    logic [OUTS-1:0] mem_q [ROWS];
    logic [3:0]      n_rows;
    logic            row_tick;
    logic [RW-1:0]   row_idx;
    phase_e          phase;
    logic [OUTS-1:0] row_word;

    assign n_rows   = rows_of(mux_sel);
    assign row_word = mem_q[row_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
        end else if (wr_en) begin
            mem_q[wr_row] <= wr_data;
        end
    end

    lcd_row_timebase #(.ROW_DIV(ROW_DIV)) u_timebase (
        .clk       (clk),
        .rst_n     (rst_n),
        .col_only  (col_only),
        .sync      (sync),
        .frame_in  (frame_in),
        .row_tick  (row_tick),
        .frame_out (frame_out)
    );

    lcd_scan_fsm #(.ROWS(ROWS)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .row_tick (row_tick),
        .sync     (sync),
        .n_rows   (n_rows),
        .row_idx  (row_idx),
        .phase    (phase)
    );

    lcd_level_map #(.OUTS(OUTS), .ROWS(ROWS)) u_map (
        .row_idx  (row_idx),
        .phase    (phase),
        .n_rows   (n_rows),
        .col_only (col_only),
        .blank    (blank),
        .force_on (force_on),
        .row_word (row_word),
        .drive    (drive)
    );

    for (genvar k = 0; k < OUTS; k++) begin : g_chk
        a_r8_blank_cols_off: assert property (@(posedge clk) disable iff (!rst_n)
            (blank && (col_only || int'(n_rows) <= k)) |->
            (drive[k*LVL_W +: LVL_W] == LVL_V2 || drive[k*LVL_W +: LVL_W] == LVL_V1));

        a_r4_mux4_no_v3: assert property (@(posedge clk) disable iff (!rst_n)
            (mux_sel == 2'b01) |-> (drive[k*LVL_W +: LVL_W] != LVL_V3));
    end

endmodule

// File: tb/test_lcd_mux_sequencer.sv
`timescale 1ns/1ps
module test_lcd_mux_sequencer;
    localparam int OUTS = 60;
    localparam int DIV  = 8;

    logic              clk = 0;
    logic              rst_n = 0;
    logic [1:0]        mux_sel = 2'b11;
    logic              col_only = 0, blank = 0, force_on = 0, sync = 0, frame_in = 0;
    logic              frame_out;
    logic              wr_en = 0;
    logic [2:0]        wr_row = 0;
    logic [OUTS-1:0]   wr_data = '0;
    logic [OUTS*3-1:0] drive;

    logic [OUTS-1:0]   bmem [8];
    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    lcd_mux_sequencer #(.OUTS(OUTS), .ROWS(8), .ROW_DIV(DIV)) i_lcd_mux_sequencer (
        .clk(clk), .rst_n(rst_n), .mux_sel(mux_sel), .col_only(col_only),
        .blank(blank), .force_on(force_on), .sync(sync), .frame_in(frame_in),
        .frame_out(frame_out), .wr_en(wr_en), .wr_row(wr_row), .wr_data(wr_data),
        .drive(drive)
    );

    function automatic int nrows(input logic [1:0] s);
        return (s == 2'b00) ? 2 : ((s == 2'b01) ? 4 : 8);
    endfunction

    function automatic logic [OUTS-1:0] pattern(input int r, input int m);
        logic [OUTS-1:0] w;
        for (int k = 0; k < OUTS; k++) w[k] = (((k * 5 + r * 3 + m) % 7) < 3);
        return w;
    endfunction

    function automatic logic [2:0] exp_lvl(input int k, input int row, input int ph);
        int n;
        logic on;
        n = nrows(mux_sel);
        if (!col_only && k < n) begin
            if (ph == 0) return (k == row) ? 3'd0 : 3'd3;
            return (k == row) ? 3'd4 : ((n == 4) ? 3'd2 : 3'd1);
        end
        on = blank ? 1'b0 : (force_on ? 1'b1 : bmem[row][k]);
        if (ph == 0) return on ? 3'd4 : 3'd2;
        return on ? 3'd0 : 3'd3;
    endfunction

    task automatic check_all(input string tag, input int row, input int ph);
        int bad;
        bad = -1;
        for (int k = OUTS - 1; k >= 0; k--)
            if (drive[3*k +: 3] !== exp_lvl(k, row, ph)) bad = k;
        n_checks++;
        if (bad >= 0) begin
            n_fail++;
            $display("FAIL %s: row %0d phase %0d output %0d actual %0d expected %0d",
                     tag, row, ph, bad, drive[3*bad +: 3], exp_lvl(bad, row, ph));
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_sync();
        sync = 1;
        tick(1);
        sync = 0;
    endtask

    task automatic write_row(input int r, input logic [OUTS-1:0] w);
        wr_en = 1; wr_row = 3'(r); wr_data = w;
        tick(1);
        wr_en = 0;
        bmem[r] = w;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic fo;
        for (int r = 0; r < 8; r++) bmem[r] = '0;
        tick(3);
        rst_n = 1;
        // R1 reset state
        check_all("R1 reset outputs", 0, 0);
        check_bit("R1 frame_out reset", frame_out, 1'b0);

        // R2 R3 R4 R5 R6: sweep all mux codes over two frames
        for (int m = 0; m < 4; m++) begin
            int n;
            mux_sel = 2'(m);
            n = nrows(mux_sel);
            for (int r = 0; r < 8; r++) write_row(r, pattern(r, m));
            do_sync();
            for (int s = 0; s <= 2 * n; s++) begin
                check_all("R2 R3 R4 R5 sweep", s % n, (s / n) % 2);
                fo = frame_out;
                tick(DIV);
                check_bit("R6 frame_out toggle", frame_out, ~fo);
            end
        end

        // R8 blank / force_on in 4-row mode
        mux_sel = 2'b01;
        do_sync();
        blank = 1; tick(1);
        check_all("R8 blank", 0, 0);
        force_on = 1; tick(1);
        check_all("R8 blank over force_on", 0, 0);
        blank = 0; tick(1);
        check_all("R8 force_on", 0, 0);
        tick(DIV - 3);
        check_all("R8 force_on next row", 1, 0);
        force_on = 0;

        // R10 write visibility
        mux_sel = 2'b11;
        do_sync();
        write_row(0, ~pattern(0, 9));
        check_all("R10 write visible", 0, 0);

        // R11 shrink mux with row out of range
        do_sync();
        tick(5 * DIV);
        check_all("R11 at row 5", 5, 0);
        mux_sel = 2'b00;
        tick(1);
        check_all("R11 back to row 0", 0, 0);

        // R9 sync in negative phase
        mux_sel = 2'b01;
        do_sync();
        tick(5 * DIV);
        check_all("R9 before sync", 1, 1);
        do_sync();
        check_all("R9 after sync", 0, 0);

        // R7 column-only follows frame_in
        mux_sel = 2'b11;
        col_only = 1;
        do_sync();
        fo = frame_out;
        tick(3 * DIV);
        check_all("R7 divider ignored", 0, 0);
        check_bit("R6 frame_out held", frame_out, fo);
        for (int e = 1; e <= 9; e++) begin
            frame_in = ~frame_in;
            tick(2);
            check_all("R7 not yet advanced", (e - 1) % 8, ((e - 1) / 8) % 2);
            tick(1);
            check_all("R7 advanced on edge", e % 8, (e / 8) % 2);
        end
        col_only = 0;

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule